// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator Front End

This block converts a stream of phase samples into instantaneous-frequency samples. Each accepted phase sample has a sample from D steps earlier subtracted from it, with D programmable from 1 to 8, which gives the comb response 1 − z^-D. Phase is an 18-bit two's-complement word in which full scale spans one turn (2π). The subtraction simply wraps and drops the carry, so a phase crossing the turn boundary still yields a small difference. The difference can then be scaled by 1, 2, 4 or 8 through a left shift. Each doubling halves the range of frequencies that can be resolved without aliasing.

A three-way source selector sits in front of the downstream post-filter. It can bypass the comb entirely, so that AM magnitude data or SSB in-phase data is filtered instead of frequency. All three sources share the phase sample's valid strobe. The output is registered, and each accepted sample appears exactly one cycle later with a one-cycle valid pulse.

Top module: `freq_disc_front`

## Requirements
- R1: While reset is asserted and after its release, with no sample accepted, `out_o` is 0 and `out_vld_o` is 0.
- R2: A sample is accepted in a cycle where `phase_vld_i` and `en_i` are both 1. `out_vld_o` is 1 in exactly the cycle after each accepted sample and 0 otherwise.
- R3: With `src_i` = 0, the output for an accepted sample is (current phase − phase accepted D samples earlier), shifted left by `mult_i`, kept to 18 bits.
- R4: `delay_i` encodes D − 1, so the codes 0 to 7 select D = 1 to 8.
- R5: The subtraction wraps modulo 2^18, which is 2π. For example, 0x3FFF0 followed by 0x00010 at D = 1 gives 0x00020, and the reverse order gives 0x3FFE0.
- R6: `mult_i` codes 0 to 3 multiply the difference by 1, 2, 4 or 8 through a left shift. Bits shifted past bit 17 are lost.
- R7: `src_i` = 1 outputs `mag_i` unchanged, and `src_i` = 2 or 3 outputs `inph_i` unchanged. In both cases the delay, subtract and shift are not applied. The phase history still advances on every accepted sample.
- R8: While `en_i` is 0, `out_vld_o` stays 0, `out_o` holds its last value, and the phase history does not advance.
- R9: In any cycle where `delay_i` differs from its value in the previous cycle, the whole history is cleared. A sample accepted in that cycle is differenced against zero and becomes the only stored entry.
- R10: The history advances only on accepted samples. Idle cycles between samples do not change which earlier sample is subtracted, and `out_o` holds through them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Discriminator enable |
| delay_i | input | 3 | Comb delay code, D − 1 |
| mult_i | input | 2 | Phase multiplier as a left-shift amount |
| src_i | input | 2 | Output source: 0 difference, 1 magnitude, 2 or 3 in-phase |
| phase_i | input | 18 | Phase sample, full scale equal to 2π |
| phase_vld_i | input | 1 | Sample strobe shared by all three sources |
| mag_i | input | 18 | Magnitude sample |
| inph_i | input | 18 | In-phase sample |
| out_o | output | 18 | Sample toward the post-filter |
| out_vld_o | output | 1 | Output valid pulse |

## Verification
The bench builds the block with its default parameters: an 18-bit sample and a history depth of 8. With these values every delay code from 1 to 8, every shift amount and every source code is reachable, and the turn boundary can be crossed with small, exactly known words. A bench model shadows the history. The model clears when the delay changes and skips disabled and idle cycles, so random runs cover delay changes made while samples are flowing, shift overflow past bit 17, and source switching while the history keeps advancing.

// File: rtl/freq_disc_pkg.sv
package freq_disc_pkg;
  typedef enum logic [1:0] {
    SRC_DIFF  = 2'd0,
    SRC_MAG   = 2'd1,
    SRC_INPH  = 2'd2,
    SRC_INPH2 = 2'd3
  } src_e;
endpackage

// File: rtl/disc_hist.sv
module disc_hist #(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          clr_i,
  input  logic [W-1:0]  din_i,
  input  logic [AW-1:0] tap_sel_i,
  output logic [W-1:0]  tap_o
);
  logic [W-1:0] hist_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q[0] <= '0;
        else if (shift_i) hist_q[0] <= din_i;
        else if (clr_i)   hist_q[0] <= '0;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q[k] <= '0;
        else if (clr_i)   hist_q[k] <= '0;
        else if (shift_i) hist_q[k] <= hist_q[k-1];
      end
    end
  end

  // cleared history reads as zero in the clearing cycle
  assign tap_o = clr_i ? '0 : hist_q[tap_sel_i];

  if (DEPTH > 1) begin : g_chk
    assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(clr_i) |-> (hist_q[DEPTH-1] == '0));
  end

  assert_hold_no_shift_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(shift_i) && !$past(clr_i)) |-> (hist_q[0] == $past(hist_q[0])));
endmodule

// File: rtl/disc_diff.sv
module disc_diff #(
  parameter int W  = 18,
  parameter int SW = 2
) (
  input  logic [W-1:0]  cur_i,
  input  logic [W-1:0]  old_i,
  input  logic [SW-1:0] shift_i,
  output logic [W-1:0]  diff_o
);
  logic [W-1:0] delta;

  // full scale is one turn: dropping the carry is the modulo-2pi wrap
  always_comb begin
    delta  = cur_i - old_i;
    diff_o = delta << shift_i;
  end
endmodule

// File: rtl/disc_out_sel.sv
module disc_out_sel
  import freq_disc_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  src_e         src_i,
  input  logic [W-1:0] diff_i,
  input  logic [W-1:0] mag_i,
  input  logic [W-1:0] inph_i,
  output logic [W-1:0] data_o,
  output logic         vld_o
);
  logic [W-1:0] pick;

  always_comb begin
    unique case (src_i)
      SRC_DIFF: pick = diff_i;
      SRC_MAG:  pick = mag_i;
      default:  pick = inph_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= load_i;
      if (load_i) data_o <= pick;
    end
  end
endmodule

// File: rtl/freq_disc_front.sv
module freq_disc_front
  import freq_disc_pkg::*;
#(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  parameter int SW    = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] delay_i,
  input  logic [SW-1:0] mult_i,
  input  logic [1:0]    src_i,
  input  logic [W-1:0]  phase_i,
  input  logic          phase_vld_i,
  input  logic [W-1:0]  mag_i,
  input  logic [W-1:0]  inph_i,
  output logic [W-1:0]  out_o,
  output logic          out_vld_o
);
  logic [AW-1:0] delay_q;
  logic          accept;
  logic          clr;
  logic [W-1:0]  tap;
  logic [W-1:0]  diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) delay_q <= '0;
    else         delay_q <= delay_i;
  end

  assign accept = phase_vld_i & en_i;
  assign clr    = (delay_i != delay_q);

  disc_hist #(.W(W), .DEPTH(DEPTH)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (accept),
    .clr_i     (clr),
    .din_i     (phase_i),
    .tap_sel_i (delay_i),
    .tap_o     (tap)
  );

  disc_diff #(.W(W), .SW(SW)) u_diff (
    .cur_i   (phase_i),
    .old_i   (tap),
    .shift_i (mult_i),
    .diff_o  (diff)
  );

  disc_out_sel #(.W(W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .src_i  (src_e'(src_i)),
    .diff_i (diff),
    .mag_i  (mag_i),
    .inph_i (inph_i),
    .data_o (out_o),
    .vld_o  (out_vld_o)
  );

  assert_vld_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o == $past(phase_vld_i && en_i));

  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !out_vld_o);

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(phase_vld_i && en_i) |-> $stable(out_o));

  assert_mag_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phase_vld_i && en_i && src_i == 2'd1) |-> (out_o == $past(mag_i)));

  assert_inph_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phase_vld_i && en_i && src_i[1]) |-> (out_o == $past(inph_i)));
endmodule

// File: tb/freq_disc_front_test.sv
module freq_disc_front_test;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] dly = '0;
  logic [1:0] mult = '0;
  logic [1:0] src = '0;
  logic [W-1:0] ph = '0, mg = '0, iq = '0;
  logic vld = 1'b0;
  logic [W-1:0] out;
  logic out_vld;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [W-1:0] mh [8];
  logic [W-1:0] exp_out = '0;
  logic exp_vld = 1'b0;
  logic [2:0] prev_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_disc_front uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .delay_i(dly), .mult_i(mult),
    .src_i(src), .phase_i(ph), .phase_vld_i(vld), .mag_i(mg), .inph_i(iq),
    .out_o(out), .out_vld_o(out_vld)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, want);
    end
  endtask

  // one cycle: drive at negedge, advance model, compare at next negedge
  task automatic step(input string tag, input logic v, input logic [W-1:0] p,
                      input logic [W-1:0] m, input logic [W-1:0] q);
    logic clr, acc;
    logic [W-1:0] tap, t;
    vld = v; ph = p; mg = m; iq = q;
    clr = (dly != prev_d);
    prev_d = dly;
    acc = v && en;
    tap = clr ? '0 : mh[dly];
    if (acc) begin
      case (src)
        2'd0: begin t = p - tap; exp_out = t << mult; end
        2'd1: exp_out = m;
        default: exp_out = q;
      endcase
    end
    exp_vld = acc;
    if (clr) for (int k = 0; k < 8; k++) mh[k] = '0;
    if (acc) begin
      for (int k = 7; k > 0; k--) mh[k] = mh[k-1];
      mh[0] = p;
    end
    @(negedge clk);
    check({tag, " vld (R2)"}, {17'd0, out_vld}, {17'd0, exp_vld});
    check(tag, out, exp_out);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) mh[k] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset out", out, '0);
    check("R1 reset vld", {17'd0, out_vld}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset out", out, '0);
    check("R1 post-reset vld", {17'd0, out_vld}, '0);

    // R3/R5: D=1 ramp and turn-boundary crossing
    en = 1'b1;
    step("R3", 1, 18'h00100, 0, 0);
    step("R3", 1, 18'h00150, 0, 0);
    step("R5 fwd", 1, 18'h3FFF0, 0, 0);
    step("R5 fwd", 1, 18'h00010, 0, 0);
    check("R5 forward wrap", out, 18'h00020);
    step("R5 rev", 1, 18'h3FFF0, 0, 0);
    check("R5 reverse wrap", out, 18'h3FFE0);

    // R4/R9: D=8, first change clears history
    dly = 3'd7;
    step("R9 clear", 1, 18'h01234, 0, 0);
    check("R9 diff vs zero", out, 18'h01234);
    dly = 3'd7;
    for (int i = 1; i < 9; i++) step("R4 D=8", 1, 18'(i * 18'h00400), 0, 0);
    check("R4 D=8 diff", out, 18'(18'h02000 - 18'h01234));

    // R6: x8 with overflow past bit 17
    mult = 2'd3;
    step("R6", 1, 18'h3F000, 0, 0);
    mult = 2'd0;

    // R7: bypass sources
    src = 2'd1; step("R7 mag", 1, 18'h00005, 18'h2AAAA, 18'h15555);
    check("R7 mag pass", out, 18'h2AAAA);
    src = 2'd2; step("R7 inph", 1, 18'h00006, 18'h2AAAA, 18'h15555);
    src = 2'd3; step("R7 inph alt", 1, 18'h00007, 18'h00111, 18'h33333);
    src = 2'd0;

    // R8: disabled cycles, history frozen
    en = 1'b0;
    repeat (4) step("R8 off", 1, 18'h3FFFF, 18'h1, 18'h2);
    en = 1'b1;
    step("R8 resume", 1, 18'h00800, 0, 0);

    // R10: idle gaps
    dly = 3'd0;
    step("R9 clear D1", 1, 18'h00050, 0, 0);
    repeat (5) step("R10 idle", 0, 18'h3ABCD, 0, 0);
    step("R10 after gap", 1, 18'h00058, 0, 0);
    check("R10 gap diff", out, 18'h00008);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 48 == 0) begin
        dly  = 3'($urandom);
        mult = 2'($urandom);
        src  = 2'($urandom);
        en   = ($urandom % 10) != 0;
      end
      step((src == 2'd0) ? "R3 rnd" : "R7 rnd", ($urandom % 4) != 0,
           18'($urandom), 18'($urandom), 18'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule